// File: doc/BRIEF.md
# Programmable Display Window Signal Generator

This block derives display timing strobes from the pixel clock. An internal pixel counter and line counter sweep one field. Three composite window outputs come from them: a read enable for an external feature chip, a read enable for a second field memory, and a general-purpose auxiliary window. Each window output is high when the pixel position lies inside its own horizontal span and the line position lies inside its own vertical span. The same counters drive a horizontal deflection pulse. Its edges are programmed in units of four pixel clocks.

A separate prescaler divides the clock into 16 µs ticks. The tick index wraps after a fixed count, which gives a free-running 10 ms cycle that carries the vertical deflection pulse. A host write port loads every position register. A single input-enable bit is also written through this port and drives its output directly. Position values go into pending registers. They reach the comparators only at a safe boundary, so a pulse is never cut in the middle of a line or a cycle.

Top module: `disp_win_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every output is low. Reset clears all position registers to zero and the input-enable bit to zero.
- R2: Register map for window channel c (c = 0 feature read enable, 1 second-memory read enable, 2 auxiliary): address 4c holds the horizontal start, 4c+1 the horizontal stop, 4c+2 the vertical start and 4c+3 the vertical stop. With pixel counter h and line counter v, a window output is high exactly when start_h ≤ h < stop_h and start_v ≤ v < stop_v. The output is registered and shows the counter position of the previous cycle.
- R3: The three window channels are independent. Programming one channel changes no other channel's output.
- R4: A span whose start equals its stop, or whose start exceeds its stop, keeps its output low.
- R5: Address 12 holds the horizontal deflection start and address 13 its stop, both in units of 4 pixels. The horizontal deflection output is high when start ≤ h/4 < stop, one cycle after position h.
- R6: The tick prescaler counts TICK_CYCLES clocks, and the tick index wraps after VD_TICKS ticks. Address 14 holds the vertical deflection start and address 15 its stop, in ticks. The vertical deflection output is high when start ≤ tick index < stop, one cycle later.
- R7: Horizontal values (window horizontal spans and horizontal deflection) take effect only after the last pixel of the current line.
- R8: Window vertical spans take effect only after the last pixel of the last line of the field.
- R9: Vertical deflection values take effect only when the tick index wraps.
- R10: A write to address 16 sets the input-enable output to data bit 0 in the next cycle. All other data bits are ignored.
- R11: Writes to addresses 17 to 31 change no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 5 | Host register address |
| wr_data | input | 16 | Host write data |
| feat_rd_en | output | 1 | Composite read enable for the external feature chip (channel 0) |
| mem2_rd_en | output | 1 | Composite read enable for the second field memory (channel 1) |
| aux_win | output | 1 | Auxiliary composite window (channel 2) |
| hdefl | output | 1 | Horizontal deflection pulse |
| vdefl | output | 1 | Vertical deflection pulse |
| in_en | output | 1 | Directly written input-enable bit |

## Verification
Every window and deflection output is due one clock after the counter position that produces it. The input-enable output is due one clock after its write. A new position value is due only after the first line end, field end or tick-index wrap that follows the write edge. The bench holds a behavioural model that advances its counters, pending values and active values on each rising edge with this same latency. It compares all six outputs with the model at every falling edge, so each result is sampled one full edge after the cycle in which it is due. Writes are placed at varied offsets inside lines, fields and deflection cycles, so the deferred-load boundaries are exercised with and without a write close to them.

// File: rtl/dwg_pkg.sv
package dwg_pkg;

    localparam int POS_W    = 16;
    localparam int ADDR_W   = 5;
    localparam int NUM_WIN  = 3;

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        pos_t start;
        pos_t stop;
    } span_t;

    typedef struct packed {
        span_t h;
        span_t v;
    } win_t;

    typedef struct packed {
        logic line_end;
        logic field_end;
        logic vd_wrap;
    } strobe_t;

    localparam addr_t A_HDEF_START = addr_t'(4 * NUM_WIN);
    localparam addr_t A_HDEF_STOP  = addr_t'(4 * NUM_WIN + 1);
    localparam addr_t A_VDEF_START = addr_t'(4 * NUM_WIN + 2);
    localparam addr_t A_VDEF_STOP  = addr_t'(4 * NUM_WIN + 3);
    localparam addr_t A_IN_EN      = addr_t'(4 * NUM_WIN + 4);

    function automatic logic span_hit(input pos_t pos, input span_t s);
        return (pos >= s.start) && (pos < s.stop);
    endfunction

endpackage

// File: rtl/dwg_timebase.sv
module dwg_timebase
    import dwg_pkg::*;
#(
    parameter int LINE_LEN    = 1024,
    parameter int FIELD_LINES = 312,
    parameter int TICK_CYCLES = 256,
    parameter int VD_TICKS    = 625
) (
    input  logic    clk,
    input  logic    rst,
    output pos_t    hpos,
    output pos_t    vpos,
    output pos_t    tpos,
    output strobe_t stb
);
    localparam int HW = (LINE_LEN    > 1) ? $clog2(LINE_LEN)    : 1;
    localparam int VW = (FIELD_LINES > 1) ? $clog2(FIELD_LINES) : 1;
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam int TW = (VD_TICKS    > 1) ? $clog2(VD_TICKS)    : 1;

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic [PW-1:0] pcnt;
    logic [TW-1:0] tcnt;

    logic h_last, v_last, p_last, t_last;

    assign h_last = (hcnt == HW'(LINE_LEN - 1));
    assign v_last = (vcnt == VW'(FIELD_LINES - 1));
    assign p_last = (pcnt == PW'(TICK_CYCLES - 1));
    assign t_last = (tcnt == TW'(VD_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            vcnt <= '0;
        end else begin
            hcnt <= h_last ? '0 : hcnt + 1'b1;
            if (h_last) begin
                vcnt <= v_last ? '0 : vcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
            tcnt <= '0;
        end else begin
            pcnt <= p_last ? '0 : pcnt + 1'b1;
            if (p_last) begin
                tcnt <= t_last ? '0 : tcnt + 1'b1;
            end
        end
    end

    assign hpos          = pos_t'(hcnt);
    assign vpos          = pos_t'(vcnt);
    assign tpos          = pos_t'(tcnt);
    assign stb.line_end  = h_last;
    assign stb.field_end = h_last && v_last;
    assign stb.vd_wrap   = p_last && t_last;

    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !p_last |=> $stable(tcnt)) else $error("tick index moved without a tick"); // R6

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !h_last |=> $stable(vcnt)) else $error("line counter moved mid-line"); // R2

endmodule

// File: rtl/dwg_regbank.sv
module dwg_regbank
    import dwg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  addr_t                wr_addr,
    input  pos_t                 wr_data,
    input  strobe_t              stb,
    output win_t [NUM_WIN-1:0]   act_win,
    output span_t                act_hd,
    output span_t                act_vd,
    output logic                 ie_q
);
    win_t [NUM_WIN-1:0] pend_win;
    span_t              pend_hd;
    span_t              pend_vd;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_win <= '0;
            pend_hd  <= '0;
            pend_vd  <= '0;
            ie_q     <= 1'b0;
        end else if (wr_en) begin
            for (int c = 0; c < NUM_WIN; c++) begin
                if (wr_addr[ADDR_W-1:2] == (ADDR_W-2)'(c)) begin
                    case (wr_addr[1:0])
                        2'd0:    pend_win[c].h.start <= wr_data;
                        2'd1:    pend_win[c].h.stop  <= wr_data;
                        2'd2:    pend_win[c].v.start <= wr_data;
                        default: pend_win[c].v.stop  <= wr_data;
                    endcase
                end
            end
            case (wr_addr)
                A_HDEF_START: pend_hd.start <= wr_data;
                A_HDEF_STOP:  pend_hd.stop  <= wr_data;
                A_VDEF_START: pend_vd.start <= wr_data;
                A_VDEF_STOP:  pend_vd.stop  <= wr_data;
                A_IN_EN:      ie_q          <= wr_data[0];
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_win <= '0;
            act_hd  <= '0;
            act_vd  <= '0;
        end else begin
            for (int c = 0; c < NUM_WIN; c++) begin
                if (stb.line_end)  act_win[c].h <= pend_win[c].h;
                if (stb.field_end) act_win[c].v <= pend_win[c].v;
            end
            if (stb.line_end) act_hd <= pend_hd;
            if (stb.vd_wrap)  act_vd <= pend_vd;
        end
    end

    AST_HSPAN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stb.line_end |=> ($stable(act_hd) && $stable(act_win[0].h))) else $error("horizontal value loaded mid-line"); // R7

    AST_VSPAN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stb.field_end |=> $stable(act_win[0].v)) else $error("vertical span loaded mid-field"); // R8

    AST_VDEF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stb.vd_wrap |=> $stable(act_vd)) else $error("vertical deflection loaded mid-cycle"); // R9

    AST_IE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_IN_EN) |=> (ie_q == $past(wr_data[0]))) else $error("input enable not written"); // R10

    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > A_IN_EN) |=> ($stable(pend_win) && $stable(pend_hd) && $stable(pend_vd) && $stable(ie_q)))
        else $error("unmapped write changed state"); // R11

endmodule

// File: rtl/dwg_window.sv
module dwg_window
    import dwg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pos_t hpos,
    input  pos_t vpos,
    input  win_t win,
    output logic win_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            win_o <= 1'b0;
        end else begin
            win_o <= span_hit(hpos, win.h) && span_hit(vpos, win.v);
        end
    end

    AST_EMPTY_LOW: assert property (@(posedge clk) disable iff (rst)
        (win.h.start >= win.h.stop || win.v.start >= win.v.stop) |=> !win_o) else $error("empty span drove output"); // R4

endmodule

// File: rtl/dwg_deflect.sv
module dwg_deflect
    import dwg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pos_t  hpos,
    input  pos_t  tpos,
    input  span_t act_hd,
    input  span_t act_vd,
    output logic  hd_o,
    output logic  vd_o
);
    pos_t hgrid;
    assign hgrid = hpos >> 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            hd_o <= 1'b0;
            vd_o <= 1'b0;
        end else begin
            hd_o <= span_hit(hgrid, act_hd);
            vd_o <= span_hit(tpos, act_vd);
        end
    end

    AST_HD_GRID: assert property (@(posedge clk) disable iff (rst)
        (hpos[1:0] != 2'b00 && $stable(act_hd)) |=> $stable(hd_o)) else $error("hd edge off the 4-pixel grid"); // R5

    AST_VD_STEP: assert property (@(posedge clk) disable iff (rst)
        ($stable(tpos) && $stable(act_vd)) |=> $stable(vd_o)) else $error("vd edge between ticks"); // R6

endmodule

// File: rtl/disp_win_gen.sv
module disp_win_gen
    import dwg_pkg::*;
#(
    parameter int LINE_LEN    = 1024,
    parameter int FIELD_LINES = 312,
    parameter int TICK_CYCLES = 256,
    parameter int VD_TICKS    = 625
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [4:0]  wr_addr,
    input  logic [15:0] wr_data,
    output logic        feat_rd_en,
    output logic        mem2_rd_en,
    output logic        aux_win,
    output logic        hdefl,
    output logic        vdefl,
    output logic        in_en
);
    pos_t               hpos, vpos, tpos;
    strobe_t            stb;
    win_t [NUM_WIN-1:0] act_win;
    span_t              act_hd, act_vd;
    logic [NUM_WIN-1:0] win_bits;

    dwg_timebase #(
        .LINE_LEN    (LINE_LEN),
        .FIELD_LINES (FIELD_LINES),
        .TICK_CYCLES (TICK_CYCLES),
        .VD_TICKS    (VD_TICKS)
    ) u_tb (
        .clk  (clk),
        .rst  (rst),
        .hpos (hpos),
        .vpos (vpos),
        .tpos (tpos),
        .stb  (stb)
    );

    dwg_regbank u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (addr_t'(wr_addr)),
        .wr_data (pos_t'(wr_data)),
        .stb     (stb),
        .act_win (act_win),
        .act_hd  (act_hd),
        .act_vd  (act_vd),
        .ie_q    (in_en)
    );

    for (genvar c = 0; c < NUM_WIN; c++) begin : g_win
        dwg_window u_win (
            .clk   (clk),
            .rst   (rst),
            .hpos  (hpos),
            .vpos  (vpos),
            .win   (act_win[c]),
            .win_o (win_bits[c])
        );
    end

    dwg_deflect u_defl (
        .clk    (clk),
        .rst    (rst),
        .hpos   (hpos),
        .tpos   (tpos),
        .act_hd (act_hd),
        .act_vd (act_vd),
        .hd_o   (hdefl),
        .vd_o   (vdefl)
    );

    assign feat_rd_en = win_bits[0];
    assign mem2_rd_en = win_bits[1];
    assign aux_win    = win_bits[2];

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !(feat_rd_en || mem2_rd_en || aux_win || hdefl || vdefl || in_en)) else $error("output high after reset"); // R1

endmodule

// File: tb/sim_disp_win_gen.sv
`timescale 1ns/1ps
module sim_disp_win_gen;
    localparam int LL = 32;
    localparam int FL = 12;
    localparam int TC = 4;
    localparam int VT = 25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        feat_rd_en, mem2_rd_en, aux_win, hdefl, vdefl, in_en;

    always #4 clk = ~clk;

    disp_win_gen #(.LINE_LEN(LL), .FIELD_LINES(FL), .TICK_CYCLES(TC), .VD_TICKS(VT)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .feat_rd_en(feat_rd_en), .mem2_rd_en(mem2_rd_en), .aux_win(aux_win),
        .hdefl(hdefl), .vdefl(vdefl), .in_en(in_en)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string cur = "R1";

    // behavioural reference model
    int h, v, p, t;
    int pend[17];
    int ah[3][2];
    int av[3][2];
    int ahd[2];
    int avd[2];
    bit e_win[3];
    bit e_hd, e_vd, e_ie;

    function automatic bit inw(int pos, int s, int e);
        return (pos >= s) && (pos < e);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            h = 0; v = 0; p = 0; t = 0;
            foreach (pend[i]) pend[i] = 0;
            for (int c = 0; c < 3; c++) begin
                ah[c][0] = 0; ah[c][1] = 0; av[c][0] = 0; av[c][1] = 0;
                e_win[c] = 1'b0;
            end
            ahd[0] = 0; ahd[1] = 0; avd[0] = 0; avd[1] = 0;
            e_hd = 1'b0; e_vd = 1'b0; e_ie = 1'b0;
        end else begin
            for (int c = 0; c < 3; c++)
                e_win[c] = inw(h, ah[c][0], ah[c][1]) && inw(v, av[c][0], av[c][1]);
            e_hd = inw(h / 4, ahd[0], ahd[1]);
            e_vd = inw(t, avd[0], avd[1]);
            if (h == LL - 1) begin
                for (int c = 0; c < 3; c++) begin
                    ah[c][0] = pend[4*c]; ah[c][1] = pend[4*c+1];
                    if (v == FL - 1) begin
                        av[c][0] = pend[4*c+2]; av[c][1] = pend[4*c+3];
                    end
                end
                ahd[0] = pend[12]; ahd[1] = pend[13];
            end
            if (p == TC - 1 && t == VT - 1) begin
                avd[0] = pend[14]; avd[1] = pend[15];
            end
            if (wr_en) begin
                if (int'(wr_addr) < 16) pend[int'(wr_addr)] = int'(wr_data);
                else if (int'(wr_addr) == 16) e_ie = wr_data[0];
            end
            if (h == LL - 1) begin
                h = 0;
                v = (v == FL - 1) ? 0 : v + 1;
            end else h = h + 1;
            if (p == TC - 1) begin
                p = 0;
                t = (t == VT - 1) ? 0 : t + 1;
            end else p = p + 1;
        end
    end

    task automatic chk(string name, string req, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) %s got %0b expected %0b at %0t", req, cur, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            chk("feat_rd_en", "R2", feat_rd_en, e_win[0]);
            chk("mem2_rd_en", "R3", mem2_rd_en, e_win[1]);
            chk("aux_win",    "R3", aux_win,    e_win[2]);
            chk("hdefl",      "R5", hdefl,      e_hd);
            chk("vdefl",      "R6", vdefl,      e_vd);
            chk("in_en",      "R10", in_en,     e_ie);
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_up();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog (%s) got timeout expected completion", cur);
            finish_up();
        end
    end

    initial begin
        cur = "R1";
        run(5);
        rst = 1'b0;
        run(10);
        // R1: every output low right after reset
        checks++;
        if ({feat_rd_en, mem2_rd_en, aux_win, hdefl, vdefl, in_en} !== 6'b0) begin
            errors++;
            $display("FAIL R1 outputs got %b expected 000000", {feat_rd_en, mem2_rd_en, aux_win, hdefl, vdefl, in_en});
        end

        cur = "R2";
        wr(0, 5); wr(1, 20); wr(2, 2); wr(3, 8);
        run(800);

        cur = "R3";
        wr(4, 0); wr(5, 32); wr(6, 0); wr(7, 12);
        wr(8, 10); wr(9, 11); wr(10, 11); wr(11, 12);
        run(800);

        cur = "R4";
        wr(0, 7); wr(1, 7); wr(10, 3); wr(11, 3);
        run(400);
        wr(0, 9); wr(1, 4);
        run(400);

        cur = "R5";
        wr(12, 2); wr(13, 5);
        run(100);
        wr(12, 0); wr(13, 8);
        run(100);

        cur = "R6";
        wr(14, 3); wr(15, 10);
        run(300);
        wr(14, 0); wr(15, 25);
        run(200);

        cur = "R7";
        wr(0, 5); wr(1, 20); wr(2, 0); wr(3, 12);
        run(400);
        run(17);
        wr(0, 12);
        run(13);
        wr(12, 3);
        run(100);

        cur = "R8";
        run(50);
        wr(2, 6);
        run(800);

        cur = "R9";
        run(37);
        wr(14, 20);
        run(250);

        cur = "R10";
        wr(16, 1); run(3);
        wr(16, 16'hFFFE); run(3);
        wr(16, 3); run(3);

        cur = "R11";
        wr(17, 16'hFFFF); wr(20, 0); wr(31, 16'h0001);
        run(400);

        finish_up();
    end
endmodule